// File: doc/BRIEF.md
# GPIO Bank with Masked-Write Alias

This block is a register-mapped general-purpose I/O bank. Its pins are grouped into 8-bit ports, four ports make up one controller, and the number of controllers is a parameter. Each port holds a function select, an output enable, an output value, a synchronised input view, and interrupt status, enable, level and clear registers. A pin whose function-select bit is set is driven from the bank's own output and enable registers. A pin whose bit is clear passes the special-function signals through unchanged.

Every register has a second address 0x80 above its plain one. A write there carries a per-bit mask in bits [15:8] and new values in bits [7:0], so one pin, or a group such as six adjacent pins, can be changed in a single bus write with no read-modify-write. The register port is a plain single-cycle bus with no back-pressure. A write takes effect at the clock edge where `wr_en` is sampled. A read sampled with `rd_en` returns its data on `rdata` one cycle later, with `rd_valid` high. The pins are plain level signals.

Top module: `gpio_bank`

## Requirements
- R1: Byte address layout: bits [ADDR_W-1:8] select the controller, bit 7 selects the masked alias, bits [6:4] select the register type, bits [3:2] select the port within the controller, and bits [1:0] are ignored. Global pad p sits in controller p>>5, port (p>>3)&3, bit p&7, so its port register lies at 0x100*ctrl + 0x10*type + 4*(port&3).
- R2: Type codes are function select 0, output enable 1, output 2, input 3, interrupt status 4, interrupt enable 5, interrupt level 6 and interrupt clear 7. A plain write (bit 7 = 0) to types 0, 1, 2, 5 or 6 stores wdata[7:0]. A read returns the stored byte on rdata[7:0] in the cycle after rd_en, with rd_valid high only in that cycle.
- R3: A write at the alias (bit 7 = 1) changes only the bits where wdata[15:8] is 1, setting them to the matching wdata[7:0] bits. A read at the alias returns the same register as the plain address.
- R4: When a function-select bit is 1, the pad's output and enable come from the output and output-enable registers. When it is 0, they come from sf_out and sf_oe.
- R5: The input register returns the pad level after two flops. Writes to it are ignored.
- R6: With its level bit at 1, a status bit sets in every cycle the synchronised pad is high. With its level bit at 0, it sets on a rising edge of the synchronised pad. Writes to the status register are ignored.
- R7: Writing 1 to a bit of the clear register clears that status bit. When a set condition falls in the same cycle, the set wins. The clear register reads as 0.
- R8: irq is high exactly when some status bit and its enable bit are both 1.
- R9: An address whose controller field is N_CTRL or above changes no register, and reading it returns 0.
- R10: After reset all registers are 0. irq and rd_valid are low, and every pad follows sf_out and sf_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 16 | Write mask [15:8] (alias only) and value [7:0] |
| rdata | output | 8 | Read data |
| rd_valid | output | 1 | rdata valid |
| pad_in | input | NPIN | Pad input levels |
| sf_out | input | NPIN | Special-function output values |
| sf_oe | input | NPIN | Special-function output enables |
| pad_out | output | NPIN | Pad output values |
| pad_oe | output | NPIN | Pad output enables |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can collide on one status bit: a hardware set and a software clear. The bench provokes the collision in both set modes. In level mode it clears while the pad stays high. In edge mode it times the clear write to land on exactly the edge where the rising edge reaches the status register, two flops after the pad changed. In both cases the bit must read back as 1, and a later clear with no event pending must leave it at 0. A second kind of collision is checked the same way: a masked write touches only some bits while the neighbouring bits keep their values, and this is judged against a register model kept in the bench.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    RK_FSEL = 3'd0,
    RK_OE   = 3'd1,
    RK_OUT  = 3'd2,
    RK_IN   = 3'd3,
    RK_ISTS = 3'd4,
    RK_IEN  = 3'd5,
    RK_ILVL = 3'd6,
    RK_ICLR = 3'd7
  } reg_kind_e;

  localparam int PORT_W        = 8;
  localparam int PORTS_PER_CTL = 4;

  function automatic logic [PORT_W-1:0] merge_bits(
    input logic [PORT_W-1:0] old_v,
    input logic [PORT_W-1:0] mask,
    input logic [PORT_W-1:0] new_v
  );
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int N_CTRL = 3,
  parameter int CTRL_W = 2,
  parameter int ADDR_W = CTRL_W + 8,
  parameter int PIDX_W = CTRL_W + 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              alias_sel,
  output reg_kind_e         kind,
  output logic [PIDX_W-1:0] pidx
);
  logic [CTRL_W-1:0] ctrl;
  logic              unused_lo;

  assign ctrl      = addr[ADDR_W-1:8];
  assign alias_sel = addr[7];
  assign kind      = reg_kind_e'(addr[6:4]);
  assign pidx      = {ctrl, addr[3:2]};
  assign hit       = (32'(ctrl) < N_CTRL);
  assign unused_lo = ^addr[1:0];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         wr_kind,
  input  logic [PORT_W-1:0] wr_mask,
  input  logic [PORT_W-1:0] wr_val,
  input  logic [PORT_W-1:0] pad_in,
  input  logic [PORT_W-1:0] sf_out,
  input  logic [PORT_W-1:0] sf_oe,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] q_fsel,
  output logic [PORT_W-1:0] q_oe,
  output logic [PORT_W-1:0] q_out,
  output logic [PORT_W-1:0] q_in,
  output logic [PORT_W-1:0] q_sts,
  output logic [PORT_W-1:0] q_ien,
  output logic [PORT_W-1:0] q_lvl,
  output logic              irq_any
);
  logic [PORT_W-1:0] fsel, oe, outr, ien, lvl, sts;
  logic [PORT_W-1:0] s1, s2, prev;
  logic [PORT_W-1:0] hit, clr, sts_n;

  assign hit   = (lvl & s2) | (~lvl & s2 & ~prev);
  assign clr   = (wr_en && wr_kind == RK_ICLR) ? (wr_mask & wr_val) : '0;
  assign sts_n = (sts & ~clr) | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsel <= '0; oe <= '0; outr <= '0; ien <= '0; lvl <= '0;
      sts  <= '0; s1 <= '0; s2 <= '0; prev <= '0;
    end else begin
      s1   <= pad_in;
      s2   <= s1;
      prev <= s2;
      sts  <= sts_n;
      if (wr_en) begin
        case (wr_kind)
          RK_FSEL: fsel <= merge_bits(fsel, wr_mask, wr_val);
          RK_OE:   oe   <= merge_bits(oe,   wr_mask, wr_val);
          RK_OUT:  outr <= merge_bits(outr, wr_mask, wr_val);
          RK_IEN:  ien  <= merge_bits(ien,  wr_mask, wr_val);
          RK_ILVL: lvl  <= merge_bits(lvl,  wr_mask, wr_val);
          default: ;
        endcase
      end
    end
  end

  assign pad_out = (fsel & outr) | (~fsel & sf_out);
  assign pad_oe  = (fsel & oe)   | (~fsel & sf_oe);
  assign q_fsel  = fsel;
  assign q_oe    = oe;
  assign q_out   = outr;
  assign q_in    = s2;
  assign q_sts   = sts;
  assign q_ien   = ien;
  assign q_lvl   = lvl;
  assign irq_any = |(sts & ien);

  // R3
  masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == RK_OUT) |=> (((outr ^ $past(outr)) & ~$past(wr_mask)) == '0));

  // R7
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_kind == RK_ICLR) |=> (($past(sts) & ~sts) == '0));

  // R2
  fsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_kind == RK_FSEL) |=> $stable(fsel));

  // R6
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[0] && s2[0]) |=> sts[0]);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N_CTRL = 3,
  parameter int CTRL_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1,
  parameter int ADDR_W = CTRL_W + 8,
  parameter int NPORT  = N_CTRL * PORTS_PER_CTL,
  parameter int NPIN   = NPORT * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [7:0]        rdata,
  output logic              rd_valid,
  input  logic [NPIN-1:0]   pad_in,
  input  logic [NPIN-1:0]   sf_out,
  input  logic [NPIN-1:0]   sf_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq
);
  localparam int PIDX_W = CTRL_W + 2;

  logic              dec_hit, dec_alias;
  reg_kind_e         dec_kind;
  logic [PIDX_W-1:0] dec_pidx;
  logic [PORT_W-1:0] eff_mask;

  logic [PORT_W-1:0] q_fsel [NPORT];
  logic [PORT_W-1:0] q_oe   [NPORT];
  logic [PORT_W-1:0] q_out  [NPORT];
  logic [PORT_W-1:0] q_in   [NPORT];
  logic [PORT_W-1:0] q_sts  [NPORT];
  logic [PORT_W-1:0] q_ien  [NPORT];
  logic [PORT_W-1:0] q_lvl  [NPORT];
  logic [NPORT-1:0]  port_irq;
  logic [PORT_W-1:0] rd_sel;

  gpio_addr_decode #(
    .N_CTRL(N_CTRL), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .PIDX_W(PIDX_W)
  ) u_dec (
    .addr(addr), .hit(dec_hit), .alias_sel(dec_alias),
    .kind(dec_kind), .pidx(dec_pidx)
  );

  assign eff_mask = dec_alias ? wdata[15:8] : '1;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic port_wr;
    assign port_wr = wr_en && dec_hit && (32'(dec_pidx) == i);
    gpio_port_regs u_port (
      .clk(clk), .rst_n(rst_n),
      .wr_en(port_wr), .wr_kind(dec_kind),
      .wr_mask(eff_mask), .wr_val(wdata[7:0]),
      .pad_in(pad_in[i*PORT_W +: PORT_W]),
      .sf_out(sf_out[i*PORT_W +: PORT_W]),
      .sf_oe(sf_oe[i*PORT_W +: PORT_W]),
      .pad_out(pad_out[i*PORT_W +: PORT_W]),
      .pad_oe(pad_oe[i*PORT_W +: PORT_W]),
      .q_fsel(q_fsel[i]), .q_oe(q_oe[i]), .q_out(q_out[i]),
      .q_in(q_in[i]), .q_sts(q_sts[i]), .q_ien(q_ien[i]),
      .q_lvl(q_lvl[i]), .irq_any(port_irq[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    if (dec_hit) begin
      case (dec_kind)
        RK_FSEL: rd_sel = q_fsel[dec_pidx];
        RK_OE:   rd_sel = q_oe[dec_pidx];
        RK_OUT:  rd_sel = q_out[dec_pidx];
        RK_IN:   rd_sel = q_in[dec_pidx];
        RK_ISTS: rd_sel = q_sts[dec_pidx];
        RK_IEN:  rd_sel = q_ien[dec_pidx];
        RK_ILVL: rd_sel = q_lvl[dec_pidx];
        default: rd_sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_sel;
    end
  end

  assign irq = |port_irq;

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int N_CTRL = 3;
  localparam int CTRL_W = 2;
  localparam int ADDR_W = CTRL_W + 8;
  localparam int NPORT  = N_CTRL * 4;
  localparam int NPIN   = NPORT * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        rd_valid, irq;
  logic [NPIN-1:0] pad_in = '0, sf_out = '0, sf_oe = '0, pad_out, pad_oe;

  int total = 0, bad = 0;
  logic [7:0] mdl [0:7][0:NPORT-1];
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank #(.N_CTRL(N_CTRL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .pad_in(pad_in), .sf_out(sf_out), .sf_oe(sf_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] aof(int p, int k, bit al);
    return ADDR_W'(((p / 4) << 8) | (int'(al) << 7) | (k << 4) | ((p % 4) << 2));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata;
    if (rd_valid !== 1'b1) begin
      total++; bad++;
      $display("FAIL R2 rd_valid actual=%b expected=1", rd_valid);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < NPORT; p++) mdl[k][p] = 8'h00;
    sf_out = {NPIN/8{8'hA5}};
    sf_oe  = {NPIN/8{8'h3C}};
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10: reset state
    chk("R10 irq", {31'd0, irq}, 32'd0);
    chk("R10 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R10 pad_out", pad_out[31:0], sf_out[31:0]);
    chk("R10 pad_oe", pad_oe[31:0], sf_oe[31:0]);
    rd(aof(5, 2, 0), d); chk("R10 out reg", {24'd0, d}, 32'd0);

    // R1 R2: plain write sweep over every port and writable type
    for (int p = 0; p < NPORT; p++)
      foreach (mdl[k]) if (k == 0 || k == 1 || k == 2 || k == 5 || k == 6) begin
        logic [7:0] v;
        v = 8'((p * 37 + k * 11 + 5) & 255);
        wr(aof(p, k, 0), {8'h00, v});
        mdl[k][p] = v;
      end
    for (int p = 0; p < NPORT; p++)
      for (int k = 0; k < 8; k++) if (k == 0 || k == 1 || k == 2 || k == 5 || k == 6) begin
        rd(aof(p, k, 0), d);
        chk("R1 R2 readback", {24'd0, d}, {24'd0, mdl[k][p]});
      end

    // R3: masked alias writes
    for (int p = 0; p < NPORT; p++)
      for (int t = 0; t < 4; t++) begin
        logic [7:0] m, v;
        int k;
        m = (t == 0) ? 8'h3F : (t == 1) ? 8'h81 : (t == 2) ? 8'h00 : 8'(8'h11 << (p % 4));
        v = 8'((p * 91 + t * 53) & 255);
        k = (t % 2) ? 1 : 2;
        wr(aof(p, k, 1), {m, v});
        mdl[k][p] = (mdl[k][p] & ~m) | (v & m);
        rd(aof(p, k, 1), d);
        chk("R3 masked", {24'd0, d}, {24'd0, mdl[k][p]});
      end

    // R4: pad routing per port
    for (int p = 0; p < NPORT; p++) begin
      logic [7:0] f, eo, ee;
      f  = mdl[0][p];
      eo = (f & mdl[2][p]) | (~f & 8'hA5);
      ee = (f & mdl[1][p]) | (~f & 8'h3C);
      chk("R4 pad_out", {24'd0, pad_out[p*8 +: 8]}, {24'd0, eo});
      chk("R4 pad_oe", {24'd0, pad_oe[p*8 +: 8]}, {24'd0, ee});
    end

    // quiet interrupts before input tests
    for (int p = 0; p < NPORT; p++) begin
      wr(aof(p, 5, 0), 16'h0000); mdl[5][p] = 8'h00;
      wr(aof(p, 6, 0), 16'h0000); mdl[6][p] = 8'h00;
    end

    // R5: input view through the synchroniser
    @(negedge clk);
    for (int p = 0; p < NPORT; p++) pad_in[p*8 +: 8] = 8'((p * 29 + 7) & 255);
    idle(3);
    for (int p = 0; p < NPORT; p++) begin
      rd(aof(p, 3, 0), d);
      chk("R5 input", {24'd0, d}, (p * 29 + 7) & 255);
    end
    wr(aof(0, 3, 0), 16'h00FF);
    wr(aof(0, 3, 1), 16'hFF00);
    rd(aof(0, 3, 0), d); chk("R5 input write ignored", {24'd0, d}, 7);

    // R7: clear everything the rising edges set
    @(negedge clk); pad_in = '0;
    idle(3);
    for (int p = 0; p < NPORT; p++) wr(aof(p, 7, 0), 16'h00FF);
    for (int p = 0; p < NPORT; p++) begin
      rd(aof(p, 4, 0), d); chk("R7 status cleared", {24'd0, d}, 0);
    end
    rd(aof(3, 7, 0), d); chk("R7 clear reads zero", {24'd0, d}, 0);
    // R6: status writes ignored
    wr(aof(2, 4, 0), 16'h00FF);
    wr(aof(2, 4, 1), 16'hFFFF);
    rd(aof(2, 4, 0), d); chk("R6 status write ignored", {24'd0, d}, 0);

    // R6 R7 R8: level mode on pad 34 (port 4 bit 2)
    wr(aof(4, 6, 1), 16'h0404);
    wr(aof(4, 5, 1), 16'h0404);
    @(negedge clk); pad_in[34] = 1'b1;
    idle(4);
    rd(aof(4, 4, 0), d); chk("R6 level set", {24'd0, d}, 8'h04);
    chk("R8 irq high", {31'd0, irq}, 1);
    wr(aof(4, 7, 0), 16'h0004);
    rd(aof(4, 4, 0), d); chk("R7 set wins over clear (level)", {24'd0, d}, 8'h04);
    @(negedge clk); pad_in[34] = 1'b0;
    idle(4);
    wr(aof(4, 7, 1), 16'h0404);
    rd(aof(4, 4, 0), d); chk("R7 level cleared", {24'd0, d}, 0);
    chk("R8 irq low", {31'd0, irq}, 0);

    // R6 R7: edge mode on pad 79 (port 9 bit 7); clear lands on the set edge
    wr(aof(9, 5, 0), 16'h0080);
    @(negedge clk); pad_in[79] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(aof(9, 7, 0), 16'h0080);
    rd(aof(9, 4, 0), d); chk("R7 set wins over clear (edge)", {24'd0, d}, 8'h80);
    chk("R8 irq edge", {31'd0, irq}, 1);
    wr(aof(9, 7, 0), 16'h0080);
    rd(aof(9, 4, 0), d); chk("R6 edge sets once", {24'd0, d}, 0);
    @(negedge clk); pad_in[79] = 1'b0;
    idle(3);
    @(negedge clk); pad_in[79] = 1'b1;
    idle(4);
    wr(aof(9, 5, 0), 16'h0000);
    chk("R8 irq masked by enable", {31'd0, irq}, 0);
    rd(aof(9, 4, 0), d); chk("R6 second edge", {24'd0, d}, 8'h80);

    // R9: controller outside the bank
    wr(ADDR_W'((3 << 8) | (2 << 4)), 16'h00FF);
    wr(ADDR_W'((3 << 8) | (0 << 4) | (3 << 2)), 16'h00FF);
    rd(ADDR_W'((3 << 8) | (2 << 4)), d); chk("R9 read zero", {24'd0, d}, 0);
    rd(aof(0, 2, 0), d); chk("R9 port 0 untouched", {24'd0, d}, {24'd0, mdl[2][0]});
    rd(aof(3, 0, 0), d); chk("R9 port 3 untouched", {24'd0, d}, {24'd0, mdl[0][3]});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule